// File: doc/BRIEF.md
# Two-Channel First-Press Lockout Latch

Two push buttons compete for a single lock. Each button drives its own set-reset storage element, and the stored state of each one is shown on its own indicator output. The first button seen pressed claims the lock. Its indicator turns on, and the other channel cannot latch while the claim lasts. The claim ends when the winning button is let go. There is no separate clear input. The block passes through idle for at least one cycle before the other channel can win.

The raw button levels come from outside the clock domain. Each one passes through a chain of flip-flops before the lockout logic sees it. A 2-bit winner code reports the lock state next to the two indicators. A press that reaches both channels in the same cycle goes to channel A. A synchronous active-high reset returns everything to idle. The buttons are expected to be debounced already.

Top module: `lockout_top`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) clears both indicators and sets winner_o to 2'b00 at that edge. This holds even when a channel was latched.
- R2: With the default of two synchroniser stages, a press applied between edges is reflected on the outputs after the third rising edge that follows it.
- R3: From idle, a press on exactly one channel latches that channel. Its indicator goes high and winner_o shows its code.
- R4: A latched channel clears on release, so the outputs return to idle three edges after the winning button is let go.
- R5: If both synchronised presses first appear in the same cycle from idle, channel A wins.
- R6: winner_o encodes idle as 2'b00, channel A as 2'b01 and channel B as 2'b10. The value 2'b11 never occurs.
- R7: When the winner is released while the other button is held, the block shows idle for exactly one cycle and then latches the other channel.
- R8: While one channel is latched, pressing or releasing the other button has no effect on either indicator or on winner_o.
- R9: At most one indicator is high at any time, and the indicators always agree with winner_o. Bit 0 of winner_o corresponds to ind_a_o and bit 1 to ind_b_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_a_i | input | 1 | Raw level of button A, high while pressed |
| btn_b_i | input | 1 | Raw level of button B, high while pressed |
| ind_a_o | output | 1 | Indicator for channel A, high while A holds the lock |
| ind_b_o | output | 1 | Indicator for channel B, high while B holds the lock |
| winner_o | output | 2 | Lock owner: 00 idle, 01 channel A, 10 channel B |

## Verification
A corrupted latch bit shows at the ports on the next cycle, because the indicators are the latch flip-flops themselves. A stale winner register or a broken inhibit shows up as two indicators high, as a code of 11, or as a mismatch between the indicators and winner_o. An error in the synchroniser depth shifts every press and every release by one or more cycles. The per-cycle reference comparison reports that shift on the first edge where the two differ. A wrong tie priority or a missing idle cycle on hand-over shows up on the cycle the contest is decided.

// File: rtl/lockout_pkg.sv
package lockout_pkg;

  typedef enum logic [1:0] {
    OWNER_NONE = 2'b00,
    OWNER_A    = 2'b01,
    OWNER_B    = 2'b10
  } owner_e;

  // Maps the next-state hold bits (bit 0 = A, bit 1 = B) to the owner code.
  function automatic owner_e owner_of(input logic [1:0] held);
    owner_e r;
    unique case (held)
      2'b01:   r = OWNER_A;
      2'b10:   r = OWNER_B;
      default: r = OWNER_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= '0;
        else       stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= '0;
        else       stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[LAST];

endmodule

// File: rtl/lockout_inhibit.sv
module lockout_inhibit #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] held_i,
  output logic           blk_o,
  output logic           open_o
);

  // One shared term produces the complementary pair.
  always_comb begin
    blk_o  = |held_i;
    open_o = ~blk_o;
  end

endmodule

// File: rtl/lockout_chan.sv
module lockout_chan (
  input  logic clk_i,
  input  logic rst_i,
  input  logic press_i,
  input  logic grant_i,
  output logic held_o,
  output logic held_d_o
);

  // Set needs press and grant; a held latch stays set only while pressed.
  always_comb held_d_o = held_o ? press_i : (press_i & grant_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) held_o <= 1'b0;
    else       held_o <= held_d_o;
  end

endmodule

// File: rtl/lockout_top.sv
module lockout_top
  import lockout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       btn_a_i,
  input  logic       btn_b_i,
  output logic       ind_a_o,
  output logic       ind_b_o,
  output logic [1:0] winner_o
);

  localparam int NCH = 2;

  logic [NCH-1:0] btn_s;
  logic [NCH-1:0] held;
  logic [NCH-1:0] held_d;
  logic [NCH-1:0] grant;
  logic           lock_blk;
  logic           lock_open;
  owner_e         owner_q;

  btn_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({btn_b_i, btn_a_i}),
    .q_o   (btn_s)
  );

  lockout_inhibit #(.NCH(NCH)) u_inh (
    .held_i (held),
    .blk_o  (lock_blk),
    .open_o (lock_open)
  );

  // Channel A has priority on a same-cycle tie.
  always_comb begin
    grant[0] = lock_open;
    grant[1] = lock_open & ~btn_s[0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    lockout_chan u_chan (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .press_i  (btn_s[ch]),
      .grant_i  (grant[ch]),
      .held_o   (held[ch]),
      .held_d_o (held_d[ch])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) owner_q <= OWNER_NONE;
    else       owner_q <= owner_of(held_d);
  end

  assign ind_a_o  = held[0];
  assign ind_b_o  = held[1];
  assign winner_o = owner_q;

endmodule

// File: rtl/lockout_chk.sv
module lockout_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] btn_s,
  input logic [1:0] ind,
  input logic [1:0] win,
  input logic       blk,
  input logic       opn
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ind == 2'b00 && win == 2'b00));

  assert_release_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (ind[0] && !btn_s[0]) |=> !ind[0]);

  assert_release_clears_b_R4: assert property (@(posedge clk) disable iff (rst)
    (ind[1] && !btn_s[1]) |=> !ind[1]);

  assert_tie_to_a_R5: assert property (@(posedge clk) disable iff (rst)
    (ind == 2'b00 && btn_s == 2'b11) |=> (ind == 2'b01));

  assert_no_code3_R6: assert property (@(posedge clk) disable iff (rst)
    win != 2'b11);

  assert_a_blocks_b_R8: assert property (@(posedge clk) disable iff (rst)
    ind[0] |=> !ind[1]);

  assert_b_blocks_a_R8: assert property (@(posedge clk) disable iff (rst)
    ind[1] |=> !ind[0]);

  assert_ind_match_R9: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(ind) && win == ind));

  assert_inhibit_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (blk != opn) && (opn == (win == 2'b00)));

endmodule

bind lockout_top lockout_chk u_chk (
  .clk   (clk_i),
  .rst   (rst_i),
  .btn_s (btn_s),
  .ind   ({ind_b_o, ind_a_o}),
  .win   (winner_o),
  .blk   (lock_blk),
  .opn   (lock_open)
);

// File: tb/sim_lockout_top.sv
`timescale 1ns/1ps
module sim_lockout_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_a = 1'b0;
  logic       btn_b = 1'b0;
  logic       ind_a, ind_b;
  logic [1:0] winner;

  integer n_chk = 0;
  integer n_fail = 0;
  bit     done = 1'b0;
  string  phase = "R1";

  // Behavioural model state: presses seen one and two edges ago, and owner.
  integer ma1 = 0, ma2 = 0, mb1 = 0, mb2 = 0, mown = 0;

  always #2.5 clk = ~clk;

  lockout_top u0 (
    .clk_i    (clk),
    .rst_i    (rst),
    .btn_a_i  (btn_a),
    .btn_b_i  (btn_b),
    .ind_a_o  (ind_a),
    .ind_b_o  (ind_b),
    .winner_o (winner)
  );

  always @(posedge clk) begin
    if (rst) begin
      ma1 = 0; ma2 = 0; mb1 = 0; mb2 = 0; mown = 0;
    end else begin
      if (mown == 1)      mown = (ma2 != 0) ? 1 : 0;
      else if (mown == 2) mown = (mb2 != 0) ? 2 : 0;
      else                mown = (ma2 != 0) ? 1 : ((mb2 != 0) ? 2 : 0);
      ma2 = ma1; ma1 = int'(btn_a);
      mb2 = mb1; mb1 = int'(btn_b);
    end
  end

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R6 and R9 on every cycle).
  always @(negedge clk) begin
    if (!done) begin
      check({phase, "/R9 ind"}, {ind_b, ind_a},
            {(mown == 2) ? 1'b1 : 1'b0, (mown == 1) ? 1'b1 : 1'b0});
      check({phase, "/R6 code"}, winner, mown[1:0]);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #0.5;
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk); #1;
    btn_a = a; btn_b = b;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    check("R1 reset idle", winner, 2'b00);

    phase = "R2";
    drive(1'b1, 1'b0);
    wait_n(1); check("R2 not yet at edge 1", winner, 2'b00);
    wait_n(1); check("R2 not yet at edge 2", winner, 2'b00);
    wait_n(1); check("R2 A latched at edge 3", {ind_b, ind_a}, 2'b01);

    phase = "R8";
    drive(1'b1, 1'b1); wait_n(5);
    check("R8 B ignored while A owns", winner, 2'b01);
    drive(1'b1, 1'b0); wait_n(4);
    check("R8 B release ignored", {ind_b, ind_a}, 2'b01);

    phase = "R4";
    drive(1'b0, 1'b0);
    wait_n(2); check("R4 still A two edges after release", winner, 2'b01);
    wait_n(1); check("R4 idle three edges after release", winner, 2'b00);

    phase = "R3";
    drive(1'b0, 1'b1); wait_n(3);
    check("R3 B alone wins", {ind_b, ind_a}, 2'b10);
    check("R6 B code", winner, 2'b10);
    drive(1'b1, 1'b1); wait_n(4);
    check("R8 A ignored while B owns", winner, 2'b10);

    phase = "R7";
    drive(1'b1, 1'b0);
    wait_n(3); check("R7 idle gap on hand-over", winner, 2'b00);
    wait_n(1); check("R7 A takes over after gap", winner, 2'b01);
    drive(1'b0, 1'b0); wait_n(5);

    phase = "R5";
    drive(1'b1, 1'b1); wait_n(3);
    check("R5 tie goes to A", {ind_b, ind_a}, 2'b01);

    phase = "R1";
    @(negedge clk); #1; rst = 1'b1;
    wait_n(1);
    check("R1 reset clears latched A", winner, 2'b00);
    @(negedge clk); #1; rst = 1'b0;
    btn_a = 1'b0; btn_b = 1'b0;
    wait_n(4);

    phase = "R3rand";
    for (int k = 0; k < 600; k++) begin
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int j = 0; j < int'($urandom_range(0, 6)); j++) @(negedge clk);
    end
    drive(1'b0, 1'b0);
    wait_n(4);
    check("R4 final idle", winner, 2'b00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule